// File: doc/BRIEF.md
# SPI Word Lane Packer

This block sits between a 32-bit FIFO and a serial shift engine. In the transmit direction it takes FIFO words and hands the engine one SPI word at a time. In the receive direction it collects SPI words from the engine and builds FIFO words from them. The word size (4 to 32 bits) sets how many SPI words share one FIFO word. If the word size divides the FIFO width exactly, the words are packed tightly. If it does not, each FIFO word carries a single SPI word.

Software programs a word size, a bit order and a transfer length in SPI words. The write is accepted only when both directions are idle, and it starts both directions with that word count. At the engine side, bit `bpw-1` of every word is always the first bit on the wire. The block reverses the low `bpw` bits whenever LSB-first order is selected. When the word count runs out, a partly filled receive word is pushed out and marked as the last word, together with a count of its valid bytes. Any unused slots in the last transmit FIFO word are dropped.

Top module: `spiw_lane_packer`

## Requirements
- R1: When `cfg_bpw` divides 32 exactly, each FIFO word holds 32/`cfg_bpw` SPI words. SPI word k of a FIFO word occupies bits [k*bpw +: bpw], so the first word sits in the lowest bits and the first byte in lane 0.
- R2: When `cfg_bpw` does not divide 32, each FIFO word carries one SPI word in bits [bpw-1:0]. On transmit, the upper bits of the FIFO word are discarded. On receive, the upper bits of the FIFO word and any `rxw_data` bits above bpw are zero.
- R3: The final receive FIFO word of a transfer has `rxf_last`=1, and `rxf_bytes` gives its valid bytes modulo 4 (0 means all four). When packed, the byte count is ceil(n*bpw/8) for n words. When unpacked, it is ceil(bpw/8) rounded up to 1, 2 or 4.
- R4: With `cfg_lsb_first`=0, SPI words pass unchanged. With `cfg_lsb_first`=1, the low bpw bits are reversed in both directions, because the engine side treats bit bpw-1 as the first serial bit.
- R5: A partly filled receive FIFO word is emitted as soon as the transfer's word count is reached, and the number of receive FIFO words equals ceil(len/words-per-FIFO-word).
- R6: Transmit presents exactly `cfg_len` SPI words and drops the unused slots of the last FIFO word. Once the count is exhausted, `txf_ready` is low and `xfer_active` falls.
- R7: A configuration write is ignored while `xfer_active` is high, and it is also ignored when `cfg_bpw` is outside 4..32. A write with a nonzero length that is accepted raises `xfer_active`.
- R8: On both outputs, data held with valid high and ready low stays stable until the handshake completes.
- R9: After reset, `txf_ready`, `txw_valid`, `rxw_ready`, `rxf_valid` and `xfer_active` are low.
- R10: A receive FIFO word that is not the last one has `rxf_last`=0 and `rxf_bytes`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_bpw | input | 6 | Bits per SPI word, 4..32 |
| cfg_lsb_first | input | 1 | 1 = LSB-first bit order |
| cfg_len | input | 16 | Transfer length in SPI words |
| xfer_active | output | 1 | A transfer is in progress in either direction |
| txf_data | input | 32 | Transmit FIFO word |
| txf_valid | input | 1 | Transmit FIFO word valid |
| txf_ready | output | 1 | Block accepts a transmit FIFO word |
| txw_data | output | 32 | SPI word to the engine, right-justified |
| txw_valid | output | 1 | SPI word valid |
| txw_ready | input | 1 | Engine takes the SPI word |
| rxw_data | input | 32 | Received SPI word, right-justified |
| rxw_valid | input | 1 | Received SPI word valid |
| rxw_ready | output | 1 | Block accepts a received SPI word |
| rxf_data | output | 32 | Packed receive FIFO word |
| rxf_valid | output | 1 | Receive FIFO word valid |
| rxf_ready | input | 1 | FIFO takes the receive word |
| rxf_last | output | 1 | Final FIFO word of the transfer |
| rxf_bytes | output | 2 | Valid bytes of the final word, 0 = all four |

## Verification
The assertions take four things for granted about the inputs. The sources keep data steady while valid is waiting. The FIFO side supplies exactly as many transmit words as the length requires. The engine side supplies exactly `cfg_len` received words. Configuration writes are only expected to take effect while the block is idle. The bench sweeps every word size from 4 to 32 in both bit orders, with lengths that leave the final FIFO word partly filled, entirely full, or holding a single word. It feeds each direction exactly the counts it computes from those rules, and it adds back-pressure and source gaps so that the hold-stable conditions are exercised. It also attempts configuration writes during a transfer and with out-of-range word sizes.

// File: rtl/spiw_pkg.sv
package spiw_pkg;

  // SPI words carried by one FIFO word for a given word size
  function automatic int words_per_fifo(int fifo_w, int bpw);
    if (bpw <= 0) return 1;
    return (fifo_w % bpw == 0) ? fifo_w / bpw : 1;
  endfunction

  // byte lanes one unpacked SPI word occupies: ceil(bpw/8) rounded to a power of two
  function automatic int lanes_per_word(int bpw);
    int need;
    int p;
    need = (bpw + 7) / 8;
    p = 1;
    for (int i = 0; i < 6; i++) if (p < need) p = p * 2;
    return p;
  endfunction

  // valid-byte code of a final FIFO word holding nwords SPI words (full word -> 0)
  function automatic int tail_bytes(int fifo_w, int bpw, int nwords);
    int b;
    if (bpw <= 0) return 0;
    if (fifo_w % bpw == 0) b = (nwords * bpw + 7) / 8;
    else                   b = lanes_per_word(bpw);
    return b % (fifo_w / 8);
  endfunction

endpackage

// File: rtl/spiw_bitflip.sv
module spiw_bitflip #(
  parameter int W     = 32,
  parameter int BPW_W = 6
) (
  input  logic [W-1:0]     in_w,
  input  logic [BPW_W-1:0] bpw,
  input  logic             flip_en,
  output logic [W-1:0]     out_w
);
  // reverses the low bpw bits when enabled; input is already masked to bpw bits
  always_comb begin
    out_w = in_w;
    if (flip_en) begin
      for (int i = 0; i < W; i++) begin
        if (i < int'(bpw)) out_w[i] = in_w[int'(bpw) - 1 - i];
      end
    end
  end
endmodule

// File: rtl/spiw_cfg.sv
module spiw_cfg #(
  parameter int FIFO_W  = 32,
  parameter int MAX_BPW = 32,
  parameter int BPW_W   = 6,
  parameter int SLOT_W  = 4,
  parameter int MIN_BPW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [BPW_W-1:0] cfg_bpw,
  input  logic             cfg_lsb_first,
  input  logic             len_nonzero,
  input  logic             idle,
  output logic [BPW_W-1:0] bpw_q,
  output logic             lsb_q,
  output logic [SLOT_W-1:0] wpf,
  output logic             start
);
  logic bpw_ok;
  logic accept;

  assign bpw_ok = (cfg_bpw >= BPW_W'(MIN_BPW)) && (cfg_bpw <= BPW_W'(MAX_BPW));
  assign accept = cfg_wr && idle && bpw_ok;
  assign start  = accept && len_nonzero;
  assign wpf    = SLOT_W'(spiw_pkg::words_per_fifo(FIFO_W, int'(bpw_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bpw_q <= BPW_W'(8);
      lsb_q <= 1'b0;
    end else if (accept) begin
      bpw_q <= cfg_bpw;
      lsb_q <= cfg_lsb_first;
    end
  end
endmodule

// File: rtl/spiw_tx_unpack.sv
module spiw_tx_unpack #(
  parameter int FIFO_W  = 32,
  parameter int MAX_BPW = 32,
  parameter int LEN_W   = 16,
  parameter int BPW_W   = 6,
  parameter int SLOT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BPW_W-1:0]  bpw,
  input  logic              lsb,
  input  logic [SLOT_W-1:0] wpf,
  input  logic              start,
  input  logic [LEN_W-1:0]  start_len,
  input  logic [FIFO_W-1:0] txf_data,
  input  logic              txf_valid,
  output logic              txf_ready,
  output logic [MAX_BPW-1:0] txw_data,
  output logic              txw_valid,
  input  logic              txw_ready,
  output logic              busy
);
  logic [FIFO_W-1:0]  hold_q;
  logic               have_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [LEN_W-1:0]   rem_q;
  logic               fifo_take;
  logic               word_fire;
  logic               word_end;
  logic [FIFO_W-1:0]  shifted;
  logic [MAX_BPW-1:0] mask;
  logic [MAX_BPW-1:0] raw;

  assign txf_ready = !have_q && (rem_q != '0);
  assign fifo_take = txf_valid && txf_ready;
  assign word_fire = have_q && txw_ready;
  assign word_end  = ((slot_q + 1'b1) == wpf) || (rem_q == LEN_W'(1));
  assign txw_valid = have_q;
  assign busy      = have_q || (rem_q != '0);

  always_comb begin
    mask    = {MAX_BPW{1'b1}} >> (MAX_BPW - int'(bpw));
    shifted = hold_q >> (int'(slot_q) * int'(bpw));
    raw     = shifted[MAX_BPW-1:0] & mask;
  end

  spiw_bitflip #(.W(MAX_BPW), .BPW_W(BPW_W)) flip_i (
    .in_w(raw), .bpw(bpw), .flip_en(lsb), .out_w(txw_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      have_q <= 1'b0;
      slot_q <= '0;
      rem_q  <= '0;
    end else if (start) begin
      rem_q  <= start_len;
      have_q <= 1'b0;
      slot_q <= '0;
    end else begin
      if (fifo_take) begin
        hold_q <= txf_data;
        have_q <= 1'b1;
        slot_q <= '0;
      end
      if (word_fire) begin
        rem_q <= rem_q - 1'b1;
        if (word_end) have_q <= 1'b0;
        else          slot_q <= slot_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spiw_rx_pack.sv
module spiw_rx_pack #(
  parameter int FIFO_W  = 32,
  parameter int MAX_BPW = 32,
  parameter int LEN_W   = 16,
  parameter int BPW_W   = 6,
  parameter int SLOT_W  = 4,
  parameter int LANE_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BPW_W-1:0]   bpw,
  input  logic               lsb,
  input  logic [SLOT_W-1:0]  wpf,
  input  logic               start,
  input  logic [LEN_W-1:0]   start_len,
  input  logic [MAX_BPW-1:0] rxw_data,
  input  logic               rxw_valid,
  output logic               rxw_ready,
  output logic [FIFO_W-1:0]  rxf_data,
  output logic               rxf_valid,
  input  logic               rxf_ready,
  output logic               rxf_last,
  output logic [LANE_W-1:0]  rxf_bytes,
  output logic               busy,
  output logic               seal
);
  logic [FIFO_W-1:0]  acc_q;
  logic [SLOT_W-1:0]  fill_q;
  logic [LEN_W-1:0]   rem_q;
  logic               full_q;
  logic               last_q;
  logic [LANE_W-1:0]  bytes_q;
  logic               word_take;
  logic [MAX_BPW-1:0] mask;
  logic [MAX_BPW-1:0] masked;
  logic [MAX_BPW-1:0] ordered;
  logic [FIFO_W-1:0]  placed;

  assign rxw_ready = !full_q && (rem_q != '0);
  assign word_take = rxw_valid && rxw_ready;
  assign seal      = word_take && (((fill_q + 1'b1) == wpf) || (rem_q == LEN_W'(1)));
  assign busy      = full_q || (rem_q != '0);
  assign rxf_data  = acc_q;
  assign rxf_valid = full_q;
  assign rxf_last  = last_q;
  assign rxf_bytes = bytes_q;

  always_comb begin
    mask   = {MAX_BPW{1'b1}} >> (MAX_BPW - int'(bpw));
    masked = rxw_data & mask;
  end

  spiw_bitflip #(.W(MAX_BPW), .BPW_W(BPW_W)) flip_i (
    .in_w(masked), .bpw(bpw), .flip_en(lsb), .out_w(ordered)
  );

  assign placed = FIFO_W'(ordered) << (int'(fill_q) * int'(bpw));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      fill_q  <= '0;
      rem_q   <= '0;
      full_q  <= 1'b0;
      last_q  <= 1'b0;
      bytes_q <= '0;
    end else if (start) begin
      acc_q   <= '0;
      fill_q  <= '0;
      rem_q   <= start_len;
      full_q  <= 1'b0;
      last_q  <= 1'b0;
      bytes_q <= '0;
    end else begin
      if (full_q && rxf_ready) begin
        full_q  <= 1'b0;
        acc_q   <= '0;
        last_q  <= 1'b0;
        bytes_q <= '0;
      end
      if (word_take) begin
        acc_q <= acc_q | placed;
        rem_q <= rem_q - 1'b1;
        if (seal) begin
          full_q <= 1'b1;
          fill_q <= '0;
          last_q <= (rem_q == LEN_W'(1));
          bytes_q <= (rem_q == LEN_W'(1))
                     ? LANE_W'(spiw_pkg::tail_bytes(FIFO_W, int'(bpw), int'(fill_q) + 1))
                     : '0;
        end else begin
          fill_q <= fill_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spiw_lane_packer.sv
module spiw_lane_packer #(
  parameter int FIFO_W  = 32,
  parameter int MAX_BPW = 32,
  parameter int LEN_W   = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_wr,
  input  logic [$clog2(MAX_BPW+1)-1:0] cfg_bpw,
  input  logic                        cfg_lsb_first,
  input  logic [LEN_W-1:0]            cfg_len,
  output logic                        xfer_active,
  input  logic [FIFO_W-1:0]           txf_data,
  input  logic                        txf_valid,
  output logic                        txf_ready,
  output logic [MAX_BPW-1:0]          txw_data,
  output logic                        txw_valid,
  input  logic                        txw_ready,
  input  logic [MAX_BPW-1:0]          rxw_data,
  input  logic                        rxw_valid,
  output logic                        rxw_ready,
  output logic [FIFO_W-1:0]           rxf_data,
  output logic                        rxf_valid,
  input  logic                        rxf_ready,
  output logic                        rxf_last,
  output logic [$clog2(FIFO_W/8)-1:0] rxf_bytes
);
  localparam int BPW_W   = $clog2(MAX_BPW + 1);
  localparam int MIN_BPW = 4;
  localparam int SLOT_W  = $clog2(FIFO_W / MIN_BPW + 1);
  localparam int LANE_W  = $clog2(FIFO_W / 8);

  logic [BPW_W-1:0]  bpw_q;
  logic              lsb_q;
  logic [SLOT_W-1:0] wpf;
  logic              start;
  logic              tx_busy;
  logic              rx_busy;
  logic              rx_seal;

  assign xfer_active = tx_busy || rx_busy;

  spiw_cfg #(
    .FIFO_W(FIFO_W), .MAX_BPW(MAX_BPW), .BPW_W(BPW_W), .SLOT_W(SLOT_W), .MIN_BPW(MIN_BPW)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_bpw(cfg_bpw),
    .cfg_lsb_first(cfg_lsb_first), .len_nonzero(cfg_len != '0), .idle(!xfer_active),
    .bpw_q(bpw_q), .lsb_q(lsb_q), .wpf(wpf), .start(start)
  );

  spiw_tx_unpack #(
    .FIFO_W(FIFO_W), .MAX_BPW(MAX_BPW), .LEN_W(LEN_W), .BPW_W(BPW_W), .SLOT_W(SLOT_W)
  ) tx_i (
    .clk(clk), .rst_n(rst_n), .bpw(bpw_q), .lsb(lsb_q), .wpf(wpf),
    .start(start), .start_len(cfg_len),
    .txf_data(txf_data), .txf_valid(txf_valid), .txf_ready(txf_ready),
    .txw_data(txw_data), .txw_valid(txw_valid), .txw_ready(txw_ready),
    .busy(tx_busy)
  );

  spiw_rx_pack #(
    .FIFO_W(FIFO_W), .MAX_BPW(MAX_BPW), .LEN_W(LEN_W), .BPW_W(BPW_W),
    .SLOT_W(SLOT_W), .LANE_W(LANE_W)
  ) rx_i (
    .clk(clk), .rst_n(rst_n), .bpw(bpw_q), .lsb(lsb_q), .wpf(wpf),
    .start(start), .start_len(cfg_len),
    .rxw_data(rxw_data), .rxw_valid(rxw_valid), .rxw_ready(rxw_ready),
    .rxf_data(rxf_data), .rxf_valid(rxf_valid), .rxf_ready(rxf_ready),
    .rxf_last(rxf_last), .rxf_bytes(rxf_bytes),
    .busy(rx_busy), .seal(rx_seal)
  );
endmodule

// File: rtl/spiw_lane_packer_chk.sv
module spiw_lane_packer_chk #(
  parameter int FIFO_W  = 32,
  parameter int MAX_BPW = 32,
  parameter int BPW_W   = 6,
  parameter int LANE_W  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wr,
  input logic               xfer_active,
  input logic               txf_ready,
  input logic [MAX_BPW-1:0] txw_data,
  input logic               txw_valid,
  input logic               txw_ready,
  input logic               rxw_ready,
  input logic [FIFO_W-1:0]  rxf_data,
  input logic               rxf_valid,
  input logic               rxf_ready,
  input logic               rxf_last,
  input logic [LANE_W-1:0]  rxf_bytes,
  input logic [BPW_W-1:0]   bpw_q,
  input logic               lsb_q,
  input logic               rx_seal
);
  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    txw_valid && !txw_ready |=> txw_valid && $stable(txw_data));

  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_valid && !rxf_ready |=> rxf_valid && $stable(rxf_data) && $stable(rxf_last) && $stable(rxf_bytes));

  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && xfer_active |=> $stable(bpw_q) && $stable(lsb_q));

  p_bpw_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bpw_q >= BPW_W'(4)) && (bpw_q <= BPW_W'(MAX_BPW)));

  p_mid_word_bytes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_valid && !rxf_last |-> rxf_bytes == '0);

  p_seal_emits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_seal |=> rxf_valid);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |-> !txf_ready && !rxw_ready && !txw_valid && !rxf_valid);
endmodule

bind spiw_lane_packer spiw_lane_packer_chk #(
  .FIFO_W(FIFO_W), .MAX_BPW(MAX_BPW), .BPW_W(BPW_W), .LANE_W(LANE_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .xfer_active(xfer_active),
  .txf_ready(txf_ready), .txw_data(txw_data), .txw_valid(txw_valid), .txw_ready(txw_ready),
  .rxw_ready(rxw_ready), .rxf_data(rxf_data), .rxf_valid(rxf_valid), .rxf_ready(rxf_ready),
  .rxf_last(rxf_last), .rxf_bytes(rxf_bytes), .bpw_q(bpw_q), .lsb_q(lsb_q), .rx_seal(rx_seal)
);

// File: tb/spiw_lane_packer_tb_top.sv
module spiw_lane_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_bpw = 6'd8;
  logic        cfg_lsb_first = 1'b0;
  logic [15:0] cfg_len = '0;
  logic        xfer_active;
  logic [31:0] txf_data = '0;
  logic        txf_valid = 1'b0;
  logic        txf_ready;
  logic [31:0] txw_data;
  logic        txw_valid;
  logic        txw_ready = 1'b0;
  logic [31:0] rxw_data = '0;
  logic        rxw_valid = 1'b0;
  logic        rxw_ready;
  logic [31:0] rxf_data;
  logic        rxf_valid;
  logic        rxf_ready = 1'b0;
  logic        rxf_last;
  logic [1:0]  rxf_bytes;

  int n_chk = 0;
  int n_bad = 0;
  int cur_bpw = 8;
  int cur_lsb = 0;
  int cur_len = 0;
  int tx_idx = 0;
  int rx_fidx = 0;
  int cyc = 0;
  bit stall_en = 1'b0;

  always #5 clk = ~clk;

  spiw_lane_packer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_bpw(cfg_bpw),
    .cfg_lsb_first(cfg_lsb_first), .cfg_len(cfg_len), .xfer_active(xfer_active),
    .txf_data(txf_data), .txf_valid(txf_valid), .txf_ready(txf_ready),
    .txw_data(txw_data), .txw_valid(txw_valid), .txw_ready(txw_ready),
    .rxw_data(rxw_data), .rxw_valid(rxw_valid), .rxw_ready(rxw_ready),
    .rxf_data(rxf_data), .rxf_valid(rxf_valid), .rxf_ready(rxf_ready),
    .rxf_last(rxf_last), .rxf_bytes(rxf_bytes)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s bpw=%0d lsb=%0d len=%0d act=%h exp=%h", req, cur_bpw, cur_lsb, cur_len, act, exp);
    end
  endtask

  function automatic logic [31:0] b_mask(int bpw);
    longint m;
    m = (longint'(1) << bpw) - 1;
    return m[31:0];
  endfunction

  function automatic logic [31:0] b_rev(logic [31:0] v, int bpw);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < bpw; i++) r = {r[30:0], v[i]};
    return r;
  endfunction

  function automatic int b_wpf(int bpw);
    return ((32 / bpw) * bpw == 32) ? 32 / bpw : 1;
  endfunction

  function automatic int b_tail(int bpw, int n);
    int bits;
    int b;
    if (b_wpf(bpw) > 1) begin
      bits = n * bpw;
      b = bits / 8 + ((bits % 8 != 0) ? 1 : 0);
    end else begin
      b = (bpw + 7) / 8;
      if (b == 3) b = 4;
    end
    return b & 3;
  endfunction

  function automatic logic [31:0] fword(int f);
    logic [31:0] x;
    x = 32'(f + 1) * 32'h9E3779B9;
    return x ^ (x >> 11);
  endfunction

  function automatic logic [31:0] sword(int k);
    logic [31:0] x;
    x = 32'(k) * 32'h2545F491 + 32'(cur_bpw * 97);
    return x ^ (x >> 7);
  endfunction

  function automatic logic [31:0] expect_tx(int k);
    int w;
    logic [31:0] v;
    w = b_wpf(cur_bpw);
    v = (fword(k / w) >> ((k % w) * cur_bpw)) & b_mask(cur_bpw);
    return (cur_lsb != 0) ? b_rev(v, cur_bpw) : v;
  endfunction

  function automatic logic [31:0] expect_rx(int f);
    int w;
    int n;
    logic [31:0] acc;
    logic [31:0] v;
    w = b_wpf(cur_bpw);
    n = cur_len - f * w;
    if (n > w) n = w;
    acc = '0;
    for (int s = 0; s < n; s++) begin
      v = sword(f * w + s) & b_mask(cur_bpw);
      if (cur_lsb != 0) v = b_rev(v, cur_bpw);
      acc = acc | (v << (s * cur_bpw));
    end
    return acc;
  endfunction

  function automatic string data_tag();
    if (cur_lsb != 0) return (b_wpf(cur_bpw) > 1) ? "R1/R4 packed lsb-first" : "R2/R4 unpacked lsb-first";
    return (b_wpf(cur_bpw) > 1) ? "R1 packed" : "R2 unpacked";
  endfunction

  // sinks: ready drive and output checks at the negative edge
  always @(negedge clk) begin
    cyc++;
    txw_ready = stall_en ? (cyc % 3 != 2) : 1'b1;
    rxf_ready = stall_en ? (cyc % 4 != 1) : 1'b1;
    if (rst_n && txw_valid && txw_ready) begin
      if (tx_idx >= cur_len) chk(1'b0, "R6 extra tx word", txw_data, 32'h0);
      else chk(txw_data == expect_tx(tx_idx), data_tag(), txw_data, expect_tx(tx_idx));
      tx_idx++;
    end
    if (rst_n && rxf_valid && rxf_ready) begin
      int nf;
      int nlast;
      bit last_exp;
      nf = (cur_len + b_wpf(cur_bpw) - 1) / b_wpf(cur_bpw);
      last_exp = (rx_fidx == nf - 1);
      nlast = cur_len - (nf - 1) * b_wpf(cur_bpw);
      chk(rxf_data == expect_rx(rx_fidx), data_tag(), rxf_data, expect_rx(rx_fidx));
      chk(rxf_last == last_exp, "R3 last flag", 32'(rxf_last), 32'(last_exp));
      if (last_exp)
        chk(int'(rxf_bytes) == b_tail(cur_bpw, nlast), "R3 tail bytes", 32'(rxf_bytes), 32'(b_tail(cur_bpw, nlast)));
      else
        chk(rxf_bytes == 2'd0, "R10 mid-word bytes", 32'(rxf_bytes), 32'h0);
      rx_fidx++;
    end
  end

  task automatic cfg_write(int bpw, int lsb, int len);
    cfg_wr = 1'b1;
    cfg_bpw = 6'(bpw);
    cfg_lsb_first = 1'(lsb);
    cfg_len = 16'(len);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic tx_feed(int n);
    for (int f = 0; f < n; f++) begin
      if (stall_en && (f % 2 == 1)) begin
        txf_valid = 1'b0;
        @(negedge clk);
      end
      txf_valid = 1'b1;
      txf_data = fword(f);
      while (!txf_ready) @(negedge clk);
      @(negedge clk);
    end
    txf_valid = 1'b0;
  endtask

  task automatic rx_feed(int n);
    for (int k = 0; k < n; k++) begin
      if (stall_en && (k % 3 == 2)) begin
        rxw_valid = 1'b0;
        @(negedge clk);
      end
      rxw_valid = 1'b1;
      rxw_data = sword(k);
      while (!rxw_ready) @(negedge clk);
      @(negedge clk);
    end
    rxw_valid = 1'b0;
  endtask

  task automatic run_xfer(int bpw, int lsb, int len, bit stall, bit poke);
    int nf;
    cur_bpw = bpw;
    cur_lsb = lsb;
    cur_len = len;
    tx_idx = 0;
    rx_fidx = 0;
    stall_en = stall;
    nf = (len + b_wpf(bpw) - 1) / b_wpf(bpw);
    cfg_write(bpw, lsb, len);
    // R7: a write while active must leave the running format untouched
    if (poke) cfg_write((bpw == 8) ? 16 : 8, 1 - lsb, 3);
    fork
      tx_feed(nf);
      rx_feed(len);
    join
    for (int i = 0; i < 200 && (xfer_active || rx_fidx < nf); i++) @(negedge clk);
    chk(tx_idx == len, "R6 tx word count", 32'(tx_idx), 32'(len));
    chk(rx_fidx == nf, "R5 rx fifo word count", 32'(rx_fidx), 32'(nf));
    chk(!xfer_active && !txf_ready, "R6 idle after count", {30'd0, xfer_active, txf_ready}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!txf_ready && !txw_valid, "R9 tx reset", {30'd0, txf_ready, txw_valid}, 32'h0);
    chk(!rxw_ready && !rxf_valid, "R9 rx reset", {30'd0, rxw_ready, rxf_valid}, 32'h0);
    chk(!xfer_active, "R9 active reset", 32'(xfer_active), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!xfer_active && !txf_ready && !rxw_ready, "R9 after release",
        {29'd0, xfer_active, txf_ready, rxw_ready}, 32'h0);

    // sweep every word size in both bit orders with a partial final word
    for (int lsb = 0; lsb < 2; lsb++) begin
      for (int bpw = 4; bpw <= 32; bpw++) begin
        run_xfer(bpw, lsb, 2 * b_wpf(bpw) + 1, bpw[0], 1'b0);
      end
    end
    // exactly full final words, single-word transfers
    for (int bpw = 4; bpw <= 32; bpw = bpw * 2) begin
      run_xfer(bpw, 0, b_wpf(bpw) * 2, 1'b1, 1'b0);
      run_xfer(bpw, 1, 1, 1'b0, 1'b0);
    end
    run_xfer(4, 0, 3, 1'b1, 1'b0);
    run_xfer(12, 1, 4, 1'b1, 1'b0);
    run_xfer(24, 0, 2, 1'b0, 1'b0);

    // R7: writes during a transfer are ignored
    run_xfer(8, 0, 9, 1'b1, 1'b1);
    run_xfer(6, 1, 5, 1'b0, 1'b1);

    // R7: out-of-range word sizes are ignored while idle
    cfg_write(3, 0, 5);
    @(negedge clk);
    chk(!xfer_active, "R7 bpw 3 ignored", 32'(xfer_active), 32'h0);
    cfg_write(33, 0, 5);
    @(negedge clk);
    chk(!xfer_active, "R7 bpw 33 ignored", 32'(xfer_active), 32'h0);
    cfg_write(0, 1, 7);
    @(negedge clk);
    chk(!xfer_active, "R7 bpw 0 ignored", 32'(xfer_active), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule